// File: doc/BRIEF.md
# Multi-Channel Down-Counting Interval Timer

This block is a register-mapped timer with `NCH` independent 32-bit channels. Each channel loads an interval value into a counter that counts down. When the counter reaches zero the channel sets a pending flag and then either reloads and keeps running (periodic) or halts (one-shot). Each channel has an interrupt line. The line is asserted while the channel's pending flag and its mask bit are both set.

Each channel picks its count tick from one of three sources: the system clock itself, a primary tick strobe, or an alternate tick strobe. It then divides that tick by a power of two. Enable takes effect through a fixed two-tick settling stage, measured in the channel's own source ticks. Software can therefore rely on a bounded stop time before it reprograms a channel. A word-wide bus gives access to the mask and pending registers and to each channel's control, interval and count registers. The bus has a strobe, a write flag, an address and data, and reads are combinational.

Top module: `tmr_top`

## Requirements
- R1: After reset, every register reads zero and every interrupt line is low.
- R2: Address map: 0x00 is the interrupt mask and 0x04 is the pending register, with bit n belonging to channel n. Channel n has control at 0x10+0x10·n, interval at 0x14+0x10·n and count at 0x18+0x10·n. Any other address reads zero. Writes to a count register are ignored.
- R3: Control layout: bit 0 is enable, bits [3:2] are the tick source, bits [6:4] are the divider code and bit 7 selects one-shot. Writing 1 to bit 1 copies the interval into the count in that same cycle and restarts the divider. Bit 1 always reads 0.
- R4: Each count event lowers the count by one, and 0xFFFFFFFF counts down through the full range. When the channel is not running, the count holds unless a reload is written.
- R5: Periodic mode: a count event that finds the count at 1 or 0 is an expiry. An expiry sets the channel's pending bit and reloads the interval, so an interval of N gives one expiry every N events.
- R6: One-shot mode: an expiry leaves the count at 0, clears the enable bit and stops the channel at once.
- R7: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. If an expiry and a clear fall in the same cycle, the bit is set.
- R8: An interrupt line is high exactly when its pending bit and its mask bit are both 1. A pending bit is set whatever the mask holds.
- R9: Tick source code 0 ticks on every clock, code 1 on `pri_tick`, and codes 2 and 3 on `alt_tick`.
- R10: With divider code k, a count event occurs on every 2^k-th source tick while the channel runs. The tick counter is cleared while the channel is stopped.
- R11: The enable bit passes through two stages that each advance on a source tick. The first count event can come on the third source tick after enable is written. After enable is cleared, at most two more source ticks can produce count events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from the address |
| pri_tick | input | 1 | Primary tick strobe, one clock wide |
| alt_tick | input | 1 | Alternate tick strobe, one clock wide |
| irq_o | output | NCH | Per-channel interrupt lines |

## Verification
The bench attacks the edges of the count: expiry at 1 against 0, a one-shot that must not expire a second time while its settling stages drain, and a reload written on a cycle that also carries a tick. A design that counted one expiry late would shift every periodic interrupt by one event. A design that let the stages drain after a one-shot expiry would raise a second, false expiry from a count of zero. The bench also checks the stop latency against slow alternate ticks, where a design that stopped on the write itself, or one that kept counting, would show a count that does not match. It checks a pending clear that coincides with an expiry, where getting the priority wrong would lose an interrupt.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int PRE_W     = 3;
  localparam int IE_OFS    = 'h00;
  localparam int ST_OFS    = 'h04;
  localparam int CH_BASE   = 'h10;
  localparam int CH_STRIDE = 'h10;
  localparam int CTL_SUB   = 'h0;
  localparam int INT_SUB   = 'h4;
  localparam int CNT_SUB   = 'h8;

  // Control register bit positions (R3)
  localparam int CB_EN  = 0;
  localparam int CB_RL  = 1;
  localparam int CB_SRC = 2;
  localparam int CB_PRE = 4;
  localparam int CB_OS  = 7;

  typedef struct packed {
    logic             os;
    logic [PRE_W-1:0] pre;
    logic [1:0]       src;
    logic             en;
  } ctl_t;

  // R9: tick source selection
  function automatic logic pick_tick(logic [1:0] src, logic pri, logic alt);
    case (src)
      2'd0:    return 1'b1;
      2'd1:    return pri;
      default: return alt;
    endcase
  endfunction

  // R5/R6: a count event at 1 or 0 is an expiry
  function automatic logic is_expiry(logic [31:0] cnt);
    return cnt <= 32'd1;
  endfunction

  // R4/R5/R6: value after one count event
  function automatic logic [31:0] count_next(logic [31:0] cnt, logic [31:0] intv, logic os);
    if (is_expiry(cnt)) return os ? 32'd0 : intv;
    return cnt - 32'd1;
  endfunction

  function automatic int reg_addr(int ch, int sub);
    return CH_BASE + CH_STRIDE * ch + sub;
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             clr,
  input  logic [PRE_W-1:0] code,
  output logic             step
);
  localparam int PC_W = (1 << PRE_W) - 1;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] mask;

  // R10: one step every 2^code running source ticks
  assign mask = PC_W'((1 << code) - 1);
  assign step = tick & run & (pc_q == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pc_q <= '0;
    else if (clr)             pc_q <= '0;
    else if (tick) begin
      if (!run || step)       pc_q <= '0;
      else                    pc_q <= pc_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pri_tick,
  input  logic          alt_tick,
  input  logic          ctl_wr,
  input  logic          intv_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctl_rd,
  output logic [DW-1:0] intv_q,
  output logic [DW-1:0] cnt_q,
  output logic          expire,
  output logic          run,
  output logic          en,
  output logic          os,
  output logic          reload
);
  ctl_t       ctl_q;
  logic [1:0] pipe_q;
  logic       tick;
  logic       step;

  assign tick   = pick_tick(ctl_q.src, pri_tick, alt_tick);
  assign run    = pipe_q[1];
  assign en     = ctl_q.en;
  assign os     = ctl_q.os;
  assign reload = ctl_wr & wdata[CB_RL];
  assign expire = step & ~reload & is_expiry(cnt_q);
  assign ctl_rd = DW'({ctl_q.os, ctl_q.pre, ctl_q.src, 1'b0, ctl_q.en});

  tmr_prescaler u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .run  (run),
    .clr  (reload),
    .code (ctl_q.pre),
    .step (step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      pipe_q <= '0;
      intv_q <= '0;
      cnt_q  <= '0;
    end else begin
      // R11: enable settles through two source-tick stages
      if (tick) pipe_q <= {pipe_q[0], ctl_q.en};
      if (reload)    cnt_q <= intv_q;
      else if (step) cnt_q <= count_next(cnt_q, intv_q, ctl_q.os);
      // R6: one-shot expiry halts at once
      if (expire && ctl_q.os) begin
        ctl_q.en <= 1'b0;
        pipe_q   <= '0;
      end
      if (ctl_wr) begin
        ctl_q.en  <= wdata[CB_EN];
        ctl_q.src <= wdata[CB_SRC +: 2];
        ctl_q.pre <= wdata[CB_PRE +: PRE_W];
        ctl_q.os  <= wdata[CB_OS];
      end
      if (intv_wr) intv_q <= wdata;
    end
  end
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              pri_tick,
  input  logic              alt_tick,
  output logic [NCH-1:0]    irq_o
);
  logic                    bus_wr;
  logic [NCH-1:0]          ie_q, st_q, st_clr;
  logic [NCH-1:0][DW-1:0]  ch_ctl_rd, ch_intv, ch_cnt;
  logic [NCH-1:0]          ch_expire, ch_run, ch_en, ch_os, ch_reload;

  assign bus_wr = bus_sel & bus_we;
  assign st_clr = (bus_wr && bus_addr == ADDR_W'(ST_OFS)) ? bus_wdata[NCH-1:0] : '0;
  // R8: interrupt line gating
  assign irq_o  = st_q & ie_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr_channel #(.DW(DW)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .pri_tick(pri_tick),
      .alt_tick(alt_tick),
      .ctl_wr  (bus_wr && bus_addr == ADDR_W'(reg_addr(g, CTL_SUB))),
      .intv_wr (bus_wr && bus_addr == ADDR_W'(reg_addr(g, INT_SUB))),
      .wdata   (bus_wdata),
      .ctl_rd  (ch_ctl_rd[g]),
      .intv_q  (ch_intv[g]),
      .cnt_q   (ch_cnt[g]),
      .expire  (ch_expire[g]),
      .run     (ch_run[g]),
      .en      (ch_en[g]),
      .os      (ch_os[g]),
      .reload  (ch_reload[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= '0;
      st_q <= '0;
    end else begin
      if (bus_wr && bus_addr == ADDR_W'(IE_OFS)) ie_q <= bus_wdata[NCH-1:0];
      // R7: write-one clear, expiry wins
      st_q <= (st_q & ~st_clr) | ch_expire;
    end
  end

  // R2: combinational read decode
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(IE_OFS)) bus_rdata = DW'(ie_q);
    if (bus_addr == ADDR_W'(ST_OFS)) bus_rdata = DW'(st_q);
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == ADDR_W'(reg_addr(i, CTL_SUB))) bus_rdata = ch_ctl_rd[i];
      if (bus_addr == ADDR_W'(reg_addr(i, INT_SUB))) bus_rdata = ch_intv[i];
      if (bus_addr == ADDR_W'(reg_addr(i, CNT_SUB))) bus_rdata = ch_cnt[i];
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_sel,
  input logic                   bus_we,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [DW-1:0]          bus_wdata,
  input logic [NCH-1:0]         irq_o,
  input logic [NCH-1:0]         ie_q,
  input logic [NCH-1:0]         st_q,
  input logic [NCH-1:0]         ch_run,
  input logic [NCH-1:0]         ch_en,
  input logic [NCH-1:0]         ch_os,
  input logic [NCH-1:0]         ch_expire,
  input logic [NCH-1:0]         ch_reload,
  input logic [NCH-1:0][DW-1:0] ch_cnt
);
  logic st_wr;
  assign st_wr = bus_sel && bus_we && bus_addr == ADDR_W'(ST_OFS);

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    logic ctl_wr_n;
    assign ctl_wr_n = bus_sel && bus_we && bus_addr == ADDR_W'(reg_addr(n, CTL_SUB));

    p_status_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ch_expire[n] |=> st_q[n]);

    p_oneshot_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ch_expire[n] && ch_os[n] && !ctl_wr_n |=> !ch_en[n] && !ch_run[n]);

    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
      st_wr && bus_wdata[n] && !ch_expire[n] |=> !st_q[n]);

    p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o[n]) |-> ie_q[n]);

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_run[n] && !ch_reload[n] |=> $stable(ch_cnt[n]));
  end
endmodule

bind tmr_top tmr_checker #(.NCH(NCH), .ADDR_W(ADDR_W), .DW(DW)) u_chk (.*);

// File: tb/tb_tmr_top.sv
module tb_tmr_top;
  localparam int NCH = 2;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        pri_tick = 0, alt_tick = 0;
  logic [NCH-1:0] irq_o;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  bit    alt_on = 0;
  string cur_req = "R1";

  // behavioural reference state
  int          m_ie, m_st;
  int          m_en[NCH], m_src[NCH], m_pre[NCH], m_os[NCH], m_p0[NCH], m_p1[NCH], m_pc[NCH];
  logic [31:0] m_int[NCH], m_cnt[NCH];

  tmr_top dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pri_tick(pri_tick), .alt_tick(alt_tick), .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    #2;
    cyc++;
    pri_tick = (cyc % 3 == 0);
    alt_tick = alt_on && (cyc % 2 == 0);
  end

  function automatic int a_ctl(int n); return 16 + 16 * n; endfunction
  function automatic int a_int(int n); return 20 + 16 * n; endfunction
  function automatic int a_cnt(int n); return 24 + 16 * n; endfunction

  function automatic logic [31:0] mread(int a);
    if (a == 0) return m_ie;
    if (a == 4) return m_st;
    for (int n = 0; n < NCH; n++) begin
      if (a == a_ctl(n)) return m_en[n] + m_src[n] * 4 + m_pre[n] * 16 + m_os[n] * 128;
      if (a == a_int(n)) return m_int[n];
      if (a == a_cnt(n)) return m_cnt[n];
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ie = 0; m_st = 0;
      for (int n = 0; n < NCH; n++) begin
        m_en[n] = 0; m_src[n] = 0; m_pre[n] = 0; m_os[n] = 0;
        m_p0[n] = 0; m_p1[n] = 0; m_pc[n] = 0; m_int[n] = 0; m_cnt[n] = 0;
      end
    end else begin
      int wr, expm;
      wr = bus_sel && bus_we;
      expm = 0;
      for (int n = 0; n < NCH; n++) begin
        int tk, run_old, rl;
        run_old = m_p1[n];
        tk = (m_src[n] == 0) ? 1 : (m_src[n] == 1) ? int'(pri_tick) : int'(alt_tick);
        rl = wr && bus_addr == a_ctl(n) && bus_wdata[1];
        if (tk) begin m_p1[n] = m_p0[n]; m_p0[n] = m_en[n]; end
        if (rl) begin
          m_cnt[n] = m_int[n]; m_pc[n] = 0;
        end else if (tk) begin
          if (!run_old) m_pc[n] = 0;
          else if (m_pc[n] == (1 << m_pre[n]) - 1) begin
            m_pc[n] = 0;
            if (m_cnt[n] <= 1) begin
              expm |= (1 << n);
              m_cnt[n] = m_os[n] ? 32'd0 : m_int[n];
            end else m_cnt[n] = m_cnt[n] - 1;
          end else m_pc[n]++;
        end
        if (expm[n] && m_os[n]) begin m_en[n] = 0; m_p0[n] = 0; m_p1[n] = 0; end
        if (wr && bus_addr == a_ctl(n)) begin
          m_en[n] = bus_wdata[0]; m_src[n] = bus_wdata[3:2];
          m_pre[n] = bus_wdata[6:4]; m_os[n] = bus_wdata[7];
        end
        if (wr && bus_addr == a_int(n)) m_int[n] = bus_wdata;
      end
      if (wr && bus_addr == 4) m_st &= ~int'(bus_wdata[NCH-1:0]);
      m_st |= expm;
      if (wr && bus_addr == 0) m_ie = bus_wdata[NCH-1:0];
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8", 32'(irq_o), 32'(m_st & m_ie));
      if (bus_sel && !bus_we) chk(cur_req, bus_rdata, mread(bus_addr));
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(posedge clk); #2;
    bus_sel = 1; bus_we = 1; bus_addr = 8'(a); bus_wdata = d;
    @(posedge clk); #2;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic peek(int a, int n);
    @(posedge clk); #2;
    bus_sel = 1; bus_we = 0; bus_addr = 8'(a);
    repeat (n) @(posedge clk);
    #2; bus_sel = 0;
  endtask

  task automatic rd_get(int a, output logic [31:0] v);
    @(posedge clk); #2;
    bus_sel = 1; bus_we = 0; bus_addr = 8'(a);
    @(negedge clk); v = bus_rdata;
    @(posedge clk); #2; bus_sel = 0;
  endtask

  task automatic rd_expect(int a, logic [31:0] e, string req);
    logic [31:0] v;
    rd_get(a, v);
    chk(req, v, e);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] v, v2;
    repeat (4) @(posedge clk);
    #2 rst_n = 1;

    // R1: reset values
    @(negedge clk); chk("R1", 32'(irq_o), 0);
    foreach (v[i]) begin end
    rd_expect(0, 0, "R1"); rd_expect(4, 0, "R1");
    rd_expect(16, 0, "R1"); rd_expect(20, 0, "R1"); rd_expect(24, 0, "R1");
    rd_expect(40, 0, "R1");

    // R3: reload bit copies interval, reads back zero
    cur_req = "R3";
    wr(20, 100); wr(16, 32'h2);
    rd_expect(24, 100, "R3"); rd_expect(16, 0, "R3");

    // R2: count register ignores writes, holes read zero
    cur_req = "R2";
    wr(24, 32'h55);
    rd_expect(24, 100, "R2"); rd_expect(12, 0, "R2"); rd_expect(20, 100, "R2");

    // R5: periodic expiry on every clock tick
    cur_req = "R5";
    wr(20, 5); wr(0, 3); wr(16, 32'h3);
    peek(24, 30);
    wr(16, 0); repeat (4) @(posedge clk);
    rd_expect(4, 1, "R5");

    // R7: write-one clear
    cur_req = "R7";
    wr(4, 0); rd_expect(4, 1, "R7");
    wr(4, 1); rd_expect(4, 0, "R7");

    // R6: one-shot stops after a single expiry
    cur_req = "R6";
    wr(0, 0); wr(36, 3); wr(32, 32'h83);
    repeat (12) @(posedge clk);
    rd_expect(40, 0, "R6"); rd_expect(32, 32'h80, "R6");
    rd_expect(4, 2, "R8");
    @(negedge clk); chk("R8", 32'(irq_o), 0);
    wr(0, 2);
    @(negedge clk); chk("R8", 32'(irq_o), 2);
    wr(4, 2);
    @(negedge clk); chk("R7", 32'(irq_o), 0);

    // R9: primary tick source
    cur_req = "R9";
    wr(36, 4); wr(32, 32'h7);
    peek(40, 40);
    wr(32, 0); repeat (4) @(posedge clk);

    // R10: divide by four
    cur_req = "R10";
    wr(20, 3); wr(16, 32'h23);
    peek(24, 50);
    wr(16, 0); repeat (4) @(posedge clk);

    // R11: alternate source, stop latency
    cur_req = "R11";
    alt_on = 1;
    wr(20, 1000); wr(16, 32'h0B);
    peek(24, 20);
    wr(16, 32'h08);
    repeat (6) @(posedge clk);
    rd_get(24, v);
    repeat (10) @(posedge clk);
    rd_get(24, v2);
    chk("R11", v2, v);
    alt_on = 0;
    wr(16, 0); repeat (4) @(posedge clk);

    // R4: full-range count from all ones
    cur_req = "R4";
    wr(20, 32'hFFFF_FFFF); wr(16, 32'h3);
    peek(24, 10);
    rd_get(24, v);
    chk("R4", 32'(v < 32'hFFFF_FFFF && v > 32'hFFFF_FF00), 1);
    wr(16, 0); repeat (4) @(posedge clk);
    rd_get(24, v); repeat (5) @(posedge clk);
    rd_expect(24, v, "R4");

    summary();
  end
endmodule